// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address to a 36-bit physical address through a small set of large, naturally aligned memory blocks. Each entry is a pair of 32-bit words. The upper word gives the effective block base, a block-length mask and two validity bits, one for supervisor and one for user. The lower word gives the physical block base, two physical-address extension fields, four cache attribute bits and a two-bit protection code. Instruction fetches and data accesses each have their own set of entries. A side-select input picks which set a lookup searches.

Software loads entries one word at a time through an indexed write port. The lookup path is purely combinational. For the effective address, privilege mode, access direction and side presented, it reports a hit, the translated physical address, the attribute bits, and whether the access breaks the entry's protection. The length mask is a thermometer code. Each one bit in it doubles the block, starting from 128 KB. Every address bit covered by the mask is excluded from the compare and passes straight through to the physical address.

Top module: `blkx_xlate`

## Requirements
- R1: Reset clears every entry. No lookup hits until an entry has been written after reset.
- R2: A write selects a slot with `cfg_side` (0 instruction, 1 data) and `cfg_idx`, and a word with `cfg_hi` (1 upper, 0 lower). The new value is seen by lookups from the clock edge that captures the write, and not before.
- R3: The upper word holds the effective base in bits 31:17 and a length mask in bits 12:2. The mask is a contiguous run of ones starting at bit 2. Mask bit k removes effective-address bit 17+k from the compare. The block size is 2^(17 + number of ones), so a zero mask gives 128 KB and 0x7FF gives 256 MB.
- R4: The physical address is built from several sources. Bits 16:0 equal the effective address. In bits 31:17, each bit covered by the mask comes from the effective address and every other bit comes from lower-word bits 31:17. Bits 35:33 come from lower-word bits 11:9, and bit 32 comes from lower-word bit 2.
- R5: An entry can match only if its validity bit for the current mode is set. Upper-word bit 1 covers supervisor mode (`lk_super`=1) and bit 0 covers user mode.
- R6: `lk_attr` is {write-through, cache-inhibit, coherent, guarded}, taken from lower-word bits 6, 5, 4 and 3 of the winning entry.
- R7: When the lower word of an instruction-side entry is written, its guarded bit (bit 3) is stored as zero.
- R8: The protection code is in lower-word bits 1:0. Code 00 flags a violation for every access. Codes 01 and 11 flag a violation for writes only. Code 10 never flags one.
- R9: When several entries of the searched side match, the lowest-numbered entry supplies all outputs.
- R10: A lookup searches only the set chosen by `lk_side` (0 instruction, 1 data). Entries of the other set have no effect on it.
- R11: When no entry matches, `lk_hit`, `lk_pa`, `lk_attr` and `lk_viol` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_side | input | 1 | Write target set: 0 instruction, 1 data |
| cfg_idx | input | IDX_W | Entry number within the set |
| cfg_hi | input | 1 | 1 writes the upper word, 0 the lower word |
| cfg_wdata | input | 32 | Word to store |
| lk_side | input | 1 | Lookup set: 0 instruction, 1 data |
| lk_super | input | 1 | 1 supervisor mode, 0 user mode |
| lk_write | input | 1 | 1 store access, 0 load or fetch |
| lk_ea | input | 32 | Effective address |
| lk_hit | output | 1 | An entry matched |
| lk_pa | output | 36 | Translated physical address |
| lk_attr | output | 4 | {write-through, cache-inhibit, coherent, guarded} |
| lk_viol | output | 1 | Access breaks the protection code |

## Verification
The assertions assume that software writes only thermometer-coded length masks into upper words. One assertion checks this at the write port, because a mask with gaps would make the pass-through and compare rules ambiguous. The bench keeps within this by loading only masks of 0, 1, 3 and 11 ones. It also places its overlapping entries so that priority, boundary misses just past a block's end, and side separation can each be seen at the outputs. Protection is checked for every code in both directions and both modes.

// File: rtl/blkx_pkg.sv
`timescale 1ns/1ps
package blkx_pkg;
    localparam int EA_W    = 32;
    localparam int PA_W    = 36;
    localparam int BLK_LSB = 17;
    localparam int BASE_W  = EA_W - BLK_LSB;
    localparam int LEN_W   = 11;
    localparam int ATTR_W  = 4;
    localparam logic [31:0] GRD_MASK = 32'h0000_0008;

    typedef struct packed {
        logic [31:0] up;
        logic [31:0] lo;
    } blkx_pair_t;
endpackage

// File: rtl/blkx_regs.sv
`timescale 1ns/1ps
module blkx_regs
    import blkx_pkg::*;
#(
    parameter  int N_PER_SIDE = 4,
    localparam int IDX_W      = $clog2(N_PER_SIDE),
    localparam int TOT        = 2 * N_PER_SIDE,
    localparam int SLOT_W     = $clog2(TOT)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic                   cfg_side,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic                   cfg_hi,
    input  logic [31:0]            cfg_wdata,
    output blkx_pair_t [TOT-1:0]   ent_o
);
    typedef struct packed {
        blkx_pair_t [TOT-1:0] ent;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic [SLOT_W-1:0] slot;
    logic [LEN_W-1:0]  wr_len;

    assign slot   = cfg_side ? SLOT_W'(N_PER_SIDE) + SLOT_W'(cfg_idx) : SLOT_W'(cfg_idx);
    assign wr_len = cfg_wdata[12:2];

    always_comb begin
        regs_d = regs_q;
        if (cfg_we) begin
            if (cfg_hi) begin
                regs_d.ent[slot].up = cfg_wdata;
            end else begin
                // instruction entries never carry the guarded attribute
                regs_d.ent[slot].lo = cfg_side ? cfg_wdata : (cfg_wdata & ~GRD_MASK);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ent_o = regs_q.ent;

    AST_WR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_hi |=> ent_o[$past(slot)].up == $past(cfg_wdata)); // R2
    AST_WR_DATA_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_hi && cfg_side |=> ent_o[$past(slot)].lo == $past(cfg_wdata)); // R2
    AST_IFETCH_NO_GRD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && !cfg_hi && !cfg_side |=> !ent_o[$past(slot)].lo[3]); // R7
    AST_LEN_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_hi |-> (wr_len & (wr_len + LEN_W'(1))) == '0); // R3
endmodule

// File: rtl/blkx_match.sv
`timescale 1ns/1ps
module blkx_match
    import blkx_pkg::*;
(
    input  blkx_pair_t      ent_i,
    input  logic [EA_W-1:0] ea_i,
    input  logic            super_i,
    output logic            hit_o,
    output logic [PA_W-1:0] pa_o
);
    logic [BASE_W-1:0] pass_msk;
    logic [BASE_W-1:0] diff;
    logic              mode_ok;
    logic              unused_bits;

    assign pass_msk = {{(BASE_W-LEN_W){1'b0}}, ent_i.up[12:2]};
    assign diff     = (ea_i[EA_W-1:BLK_LSB] ^ ent_i.up[31:BLK_LSB]) & ~pass_msk;
    assign mode_ok  = super_i ? ent_i.up[1] : ent_i.up[0];
    assign hit_o    = mode_ok && (diff == '0);

    assign pa_o = {ent_i.lo[11:9], ent_i.lo[2],
                   (ent_i.lo[31:BLK_LSB] & ~pass_msk) | (ea_i[EA_W-1:BLK_LSB] & pass_msk),
                   ea_i[BLK_LSB-1:0]};

    assign unused_bits = ^{ent_i.up[16:13], ent_i.lo[16:12], ent_i.lo[8:3], ent_i.lo[1:0]};
endmodule

// File: rtl/blkx_select.sv
`timescale 1ns/1ps
module blkx_select
    import blkx_pkg::*;
#(
    parameter int N = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N-1:0]               hit_i,
    input  logic [N-1:0][PA_W-1:0]     pa_i,
    input  logic [N-1:0][31:0]         lo_i,
    output logic                       hit_o,
    output logic [PA_W-1:0]            pa_o,
    output logic [31:0]                lo_o
);
    always_comb begin
        hit_o = 1'b0;
        pa_o  = '0;
        lo_o  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                hit_o = 1'b1;
                pa_o  = pa_i[i];
                lo_o  = lo_i[i];
            end
        end
    end

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i[0] |-> (pa_o == pa_i[0]) && (lo_o == lo_i[0])); // R9
endmodule

// File: rtl/blkx_xlate.sv
`timescale 1ns/1ps
module blkx_xlate
    import blkx_pkg::*;
#(
    parameter  int N_PER_SIDE = 4,
    localparam int IDX_W      = $clog2(N_PER_SIDE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_side,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic              cfg_hi,
    input  logic [31:0]       cfg_wdata,
    input  logic              lk_side,
    input  logic              lk_super,
    input  logic              lk_write,
    input  logic [EA_W-1:0]   lk_ea,
    output logic              lk_hit,
    output logic [PA_W-1:0]   lk_pa,
    output logic [ATTR_W-1:0] lk_attr,
    output logic              lk_viol
);
    localparam int TOT = 2 * N_PER_SIDE;

    blkx_pair_t [TOT-1:0]              ent;
    logic       [N_PER_SIDE-1:0]       hit_v;
    logic       [N_PER_SIDE-1:0][PA_W-1:0] pa_v;
    logic       [N_PER_SIDE-1:0][31:0] lo_v;
    logic       [31:0]                 lo_sel;
    logic       [1:0]                  pp_sel;
    logic                              unused_lo;

    blkx_regs #(.N_PER_SIDE(N_PER_SIDE)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_side(cfg_side),
        .cfg_idx(cfg_idx), .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata), .ent_o(ent)
    );

    for (genvar g = 0; g < N_PER_SIDE; g++) begin : g_ent
        blkx_pair_t cand;
        assign cand    = lk_side ? ent[N_PER_SIDE + g] : ent[g];
        assign lo_v[g] = cand.lo;
        blkx_match match_i (
            .ent_i(cand), .ea_i(lk_ea), .super_i(lk_super),
            .hit_o(hit_v[g]), .pa_o(pa_v[g])
        );
    end

    blkx_select #(.N(N_PER_SIDE)) sel_i (
        .clk(clk), .rst_n(rst_n), .hit_i(hit_v), .pa_i(pa_v), .lo_i(lo_v),
        .hit_o(lk_hit), .pa_o(lk_pa), .lo_o(lo_sel)
    );

    assign pp_sel  = lo_sel[1:0];
    assign lk_attr = lo_sel[6:3];
    assign lk_viol = lk_hit && ((pp_sel == 2'b00) || (lk_write && (pp_sel != 2'b10)));

    assign unused_lo = ^{lo_sel[31:7], lo_sel[2]};

    AST_RST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !lk_hit); // R1
    AST_PA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[BLK_LSB-1:0] == lk_ea[BLK_LSB-1:0]); // R4
    AST_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit && !lk_write && (pp_sel != 2'b00) |-> !lk_viol); // R8
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_pa == '0) && (lk_attr == '0) && !lk_viol); // R11
endmodule

// File: tb/blkx_xlate_tb_top.sv
`timescale 1ns/1ps
module blkx_xlate_tb_top;
    typedef struct packed {
        logic        side;
        logic        sup;
        logic        wr;
        logic [31:0] ea;
        logic        hit;
        logic [35:0] pa;
        logic [3:0]  attr;
        logic        viol;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b0, 32'h10000100, 1'b1, 36'h080000100, 4'b1000, 1'b0},
        '{1'b1, 1'b0, 1'b1, 32'h10000100, 1'b1, 36'h080000100, 4'b1000, 1'b0},
        '{1'b1, 1'b1, 1'b0, 32'h12345678, 1'b1, 36'hB22345678, 4'b0101, 1'b0},
        '{1'b1, 1'b1, 1'b1, 32'h12345678, 1'b1, 36'hB22345678, 4'b0101, 1'b1},
        '{1'b1, 1'b0, 1'b0, 32'h12345678, 1'b0, 36'h0,         4'b0000, 1'b0},
        '{1'b1, 1'b0, 1'b0, 32'h400E1234, 1'b1, 36'h0006E1234, 4'b0010, 1'b1},
        '{1'b1, 1'b0, 1'b0, 32'h40100000, 1'b0, 36'h0,         4'b0000, 1'b0},
        '{1'b1, 1'b1, 1'b0, 32'h400E1234, 1'b0, 36'h0,         4'b0000, 1'b0},
        '{1'b1, 1'b1, 1'b1, 32'h6003FFFC, 1'b1, 36'h07003FFFC, 4'b0000, 1'b1},
        '{1'b1, 1'b1, 1'b0, 32'h6003FFFC, 1'b1, 36'h07003FFFC, 4'b0000, 1'b0},
        '{1'b1, 1'b1, 1'b0, 32'h60040000, 1'b0, 36'h0,         4'b0000, 1'b0},
        '{1'b0, 1'b1, 1'b0, 32'h10001000, 1'b1, 36'h090001000, 4'b0100, 1'b0},
        '{1'b0, 1'b1, 1'b0, 32'h12345678, 1'b0, 36'h0,         4'b0000, 1'b0},
        '{1'b1, 1'b1, 1'b0, 32'h10001000, 1'b1, 36'h080001000, 4'b1000, 1'b0},
        '{1'b1, 1'b1, 1'b0, 32'h10020000, 1'b1, 36'hB20020000, 4'b0101, 1'b0}
    };

    function automatic string vec_req(int i);
        case (i)
            0:  return "R9 priority, R4 address";
            1:  return "R8 read-write code, R5 user";
            2:  return "R3 256MB mask, R4 extension, R6";
            3:  return "R8 read-only write";
            4:  return "R5 user invalid, R11";
            5:  return "R8 no-access code, R3 1MB";
            6:  return "R3 past block end";
            7:  return "R5 supervisor invalid";
            8:  return "R8 code 11 write";
            9:  return "R8 code 11 read";
            10: return "R3 past 256KB end";
            11: return "R7 guarded cleared, R10";
            12: return "R10 instruction set only";
            13: return "R10 data set";
            default: return "R3 128KB boundary, R9";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_side = 1'b0, cfg_hi = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        lk_side = 1'b0, lk_super = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_ea = '0;
    logic        lk_hit, lk_viol;
    logic [35:0] lk_pa;
    logic [3:0]  lk_attr;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    blkx_xlate #(.N_PER_SIDE(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_side(cfg_side),
        .cfg_idx(cfg_idx), .cfg_hi(cfg_hi), .cfg_wdata(cfg_wdata),
        .lk_side(lk_side), .lk_super(lk_super), .lk_write(lk_write), .lk_ea(lk_ea),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_attr(lk_attr), .lk_viol(lk_viol)
    );

    task automatic wr_word(input logic side, input logic [1:0] idx, input logic hi,
                           input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_side = side; cfg_idx = idx; cfg_hi = hi; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check(input vec_t v, input string req);
        n_chk++;
        if (lk_hit !== v.hit || lk_pa !== v.pa || lk_attr !== v.attr || lk_viol !== v.viol) begin
            n_bad++;
            $display("FAIL %s ea=%h: got hit=%b pa=%h attr=%b viol=%b, expected hit=%b pa=%h attr=%b viol=%b",
                     req, v.ea, lk_hit, lk_pa, lk_attr, lk_viol, v.hit, v.pa, v.attr, v.viol);
        end
    endtask

    task automatic look(input vec_t v, input string req);
        @(negedge clk);
        lk_side = v.side; lk_super = v.sup; lk_write = v.wr; lk_ea = v.ea;
        #2;
        check(v, req);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: nothing hits after reset
        look('{1'b1, 1'b1, 1'b0, 32'h10000100, 1'b0, 36'h0, 4'b0, 1'b0}, "R1 reset clear");

        wr_word(1'b1, 2'd0, 1'b1, 32'h10000003);
        wr_word(1'b1, 2'd0, 1'b0, 32'h80000042);
        wr_word(1'b1, 2'd1, 1'b1, 32'h10001FFE);
        wr_word(1'b1, 2'd1, 1'b0, 32'h20000A2D);
        wr_word(1'b1, 2'd2, 1'b1, 32'h4000001D);
        wr_word(1'b1, 2'd2, 1'b0, 32'h00600010);
        wr_word(1'b1, 2'd3, 1'b1, 32'h60000006);
        wr_word(1'b1, 2'd3, 1'b0, 32'h70000003);
        wr_word(1'b0, 2'd0, 1'b1, 32'h10000003);
        wr_word(1'b0, 2'd0, 1'b0, 32'h9000002A);

        for (int i = 0; i < NV; i++) look(VECS[i], vec_req(i));

        // R2: write timing - not visible before the capturing edge, visible after
        @(negedge clk);
        lk_side = 1'b1; lk_super = 1'b1; lk_write = 1'b1; lk_ea = 32'h10000100;
        cfg_we = 1'b1; cfg_side = 1'b1; cfg_idx = 2'd0; cfg_hi = 1'b0; cfg_wdata = 32'h80000041;
        #2;
        check('{1'b1, 1'b1, 1'b1, 32'h10000100, 1'b1, 36'h080000100, 4'b1000, 1'b0}, "R2 before edge");
        @(negedge clk);
        cfg_we = 1'b0;
        #2;
        check('{1'b1, 1'b1, 1'b1, 32'h10000100, 1'b1, 36'h080000100, 4'b1000, 1'b1}, "R2 after edge");

        // R1: reset in mid-run drops every entry
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look('{1'b1, 1'b1, 1'b0, 32'h10000100, 1'b0, 36'h0, 4'b0, 1'b0}, "R1 reset mid-run");
        look('{1'b0, 1'b1, 1'b0, 32'h10001000, 1'b0, 36'h0, 4'b0, 1'b0}, "R1 reset instruction side");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule